// File: doc/BRIEF.md
# Tree-Walking Huffman Stream Decoder

This block expands a Huffman-compressed image from memory into 32-bit output words. A one-cycle start pulse gives a source and a destination byte address. The block then fetches a 32-bit header, a tree-size byte and the root node over a read port. After that it walks the tree one bitstream bit at a time. Each tree node is fetched only when the walk reaches it. Decoded symbols are packed into words, and each full word goes out through a write port.

The header's low nibble picks the symbol width: the value 8 selects 8-bit symbols and any other value selects 4-bit symbols. In 4-bit mode two decoded symbols are paired into one byte before the byte is packed. Each tree node holds a 6-bit relative child offset and two leaf flags. The walk position accumulates from node to node until a leaf is reached. The read port and the write port each use a single-outstanding request/valid handshake. A done pulse ends every job, and this includes jobs that abort at the header.

Top module: `huff_decoder`

## Requirements
- R1: The header is a little-endian 32-bit word. Bits 3:0 equal to 8 select 8-bit symbols, and any other value selects 4-bit symbols. Bits 31:8 hold the output length in bytes.
- R2: The read order at job start is fixed. First a word read at src, then a byte read at src+4 (the tree size T), then a byte read at src+5 (the root). The first bitstream word is then read at src+5+2*T+1. Byte reads return the byte in data bits 7:0.
- R3: Bitstream words are consumed most significant bit first. After bit 0 of a word is used, the next bitstream word is read at the previous bitstream address plus 4.
- R4: At each step the walk position becomes 1 if it is 0. Otherwise it grows by 2*((node & 0x3F)+1). The child read address is the root address plus the new position, plus 1 when the bit is 1.
- R5: A 1 bit selects the child at position+1, and that child is a leaf if bit 6 of the current node is set. A 0 bit selects the child at position, and that child is a leaf if bit 7 of the current node is set.
- R6: After a leaf byte is emitted, the walk restarts from the root at position 0.
- R7: In 4-bit mode the low nibble of the first decoded leaf becomes bits 3:0 of the output byte, and the low nibble of the second becomes bits 7:4.
- R8: Output bytes pack little-endian into 32-bit words. The words are written to dst, dst+4 and so on. Writing stops after ceil(length/4) words.
- R9: If bits 27:25 of src+4 are all zero, or bits 27:25 of src+4+length are all zero, the job ends with done and writes nothing.
- R10: A read or write request, together with its address and data, stays unchanged until it is accepted by rd_valid_i or wr_ack_i. A read request and a write request are never raised in the same cycle.
- R11: busy_o rises the cycle after an accepted start and falls the cycle after the one-cycle done_o pulse. A start that arrives while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job start pulse |
| src_addr_i | input | 32 | Compressed image byte address |
| dst_addr_i | input | 32 | Output byte address |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_req_o | output | 1 | Read request |
| rd_word_o | output | 1 | 1 = word read, 0 = byte read |
| rd_addr_o | output | 32 | Read byte address |
| rd_valid_i | input | 1 | Read data valid, accepts the request |
| rd_data_i | input | 32 | Read data, with the byte in 7:0 for byte reads |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 32 | Packed output word |
| wr_ack_i | input | 1 | Write accepted |

## Verification
A corrupted walk position or current node shows up at rd_addr_o on the very next node read, because the child address comes straight from those two registers. A wrong node can still decode the right symbols by accident, so the bench uses a three-leaf tree with a nonzero child offset and unused filler bytes. A walk that lands on a filler byte places 0xEE in the output word, and that shows within one output word. Packer or nibble-order faults show in the first written word. Length and bitstream-address faults show as a wrong write count or a wrong word-read address when the job ends.

// File: rtl/huff_pkg.sv
package huff_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_TSZ, ST_ROOT, ST_BITS, ST_NODE, ST_ADV, ST_WRITE, ST_DONE
  } huff_state_e;

  localparam logic [3:0] MODE8_CODE = 4'h8;
  localparam int NODE_OFS_W = 6;
  localparam int RIGHT_LEAF_BIT = 6;
  localparam int LEFT_LEAF_BIT = 7;
endpackage

// File: rtl/huff_bitbuf.sv
module huff_bitbuf #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              last_o
);
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= IDX_W'(WORD_W-1);
    end else if (load_i) begin
      word_q <= word_i;
      idx_q  <= IDX_W'(WORD_W-1);
    end else if (shift_i) begin
      idx_q  <= idx_q - 1'b1;
    end
  end

  assign bit_o  = word_q[idx_q];
  assign last_o = (idx_q == '0);

  assert_load_xor_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/huff_walk.sv
module huff_walk #(
  parameter int ADDR_W = 32,
  parameter int POS_W  = 10
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [7:0]        node_i,
  input  logic              bit_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [POS_W-1:0]  pos_nxt_o,
  output logic [ADDR_W-1:0] child_addr_o,
  output logic              leaf_o
);
  import huff_pkg::*;
  logic [POS_W-1:0] step;

  always_comb begin
    step = POS_W'({1'b0, node_i[NODE_OFS_W-1:0]}) + POS_W'(1);
    step = step << 1;
    pos_nxt_o    = (pos_i == '0) ? POS_W'(1) : pos_i + step;
    child_addr_o = base_i + ADDR_W'(pos_nxt_o) + ADDR_W'(bit_i);
    leaf_o       = bit_i ? node_i[RIGHT_LEAF_BIT] : node_i[LEFT_LEAF_BIT];
  end
endmodule

// File: rtl/huff_packer.sv
module huff_packer #(
  parameter int WORD_W = 32,
  localparam int BYTES = WORD_W / 8,
  localparam int CNT_W = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              mode8_i,
  input  logic              sym_valid_i,
  input  logic [7:0]        sym_i,
  input  logic              take_i,
  output logic              word_rdy_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        lo_q;
  logic              have_lo_q;
  logic              rdy_q;
  logic [7:0]        byte_v;

  assign byte_v = mode8_i ? sym_i : {sym_i[3:0], lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      lo_q      <= '0;
      have_lo_q <= 1'b0;
      rdy_q     <= 1'b0;
    end else if (clr_i) begin
      cnt_q     <= '0;
      have_lo_q <= 1'b0;
      rdy_q     <= 1'b0;
    end else begin
      if (take_i) rdy_q <= 1'b0;
      if (sym_valid_i) begin
        if (mode8_i || have_lo_q) begin
          acc_q[cnt_q*8 +: 8] <= byte_v;
          have_lo_q <= 1'b0;
          cnt_q     <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(BYTES-1)) rdy_q <= 1'b1;
        end else begin
          lo_q      <= sym_i[3:0];
          have_lo_q <= 1'b1;
        end
      end
    end
  end

  assign word_rdy_o = rdy_q;
  assign word_o     = acc_q;

  assert_word_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_rdy_o && !take_i && !clr_i |=> word_rdy_o && $stable(word_o));
  assert_no_sym_when_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_rdy_o |-> !sym_valid_i);
endmodule

// File: rtl/huff_decoder.sv
module huff_decoder #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 24,
  parameter int POS_W     = 10,
  parameter int REGION_LO = 25,
  parameter int REGION_HI = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_req_o,
  output logic              rd_word_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i
);
  import huff_pkg::*;
  localparam int WBYTES = DATA_W / 8;

  huff_state_e state_q;
  logic [ADDR_W-1:0] src_q, base_q, bits_q, dst_q;
  logic signed [LEN_W:0] rem_q, rem_after;
  logic [POS_W-1:0] pos_q, pos_nxt;
  logic [7:0] cur_q, root_q;
  logic mode8_q, need_fetch_q;

  logic bit_v, last_v, leaf_v;
  logic [ADDR_W-1:0] child_addr;
  logic word_rdy;
  logic [DATA_W-1:0] word_v;

  logic [ADDR_W-1:0] hdr_next, hdr_end;
  logic [LEN_W-1:0]  hdr_len;
  logic abort_v, rd_fire, wr_fire, sym_fire, buf_load, buf_shift, start_ok;

  assign start_ok  = start_i && (state_q == ST_IDLE);
  assign rd_fire   = rd_req_o && rd_valid_i;
  assign wr_fire   = wr_req_o && wr_ack_i;
  assign hdr_len   = rd_data_i[8 +: LEN_W];
  assign hdr_next  = src_q + ADDR_W'(4);
  assign hdr_end   = hdr_next + ADDR_W'(hdr_len);
  assign abort_v   = (hdr_next[REGION_HI:REGION_LO] == '0) ||
                     (hdr_end[REGION_HI:REGION_LO] == '0);
  assign rem_after = rem_q - (LEN_W+1)'(WBYTES);
  assign sym_fire  = (state_q == ST_NODE) && rd_valid_i && leaf_v;
  assign buf_load  = (state_q == ST_BITS) && rd_valid_i;
  assign buf_shift = (state_q == ST_NODE) && rd_valid_i;

  huff_bitbuf #(.WORD_W(DATA_W)) u_bits (
    .clk_i, .rst_ni, .load_i(buf_load), .word_i(rd_data_i),
    .shift_i(buf_shift), .bit_o(bit_v), .last_o(last_v)
  );

  huff_walk #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_walk (
    .pos_i(pos_q), .node_i(cur_q), .bit_i(bit_v), .base_i(base_q),
    .pos_nxt_o(pos_nxt), .child_addr_o(child_addr), .leaf_o(leaf_v)
  );

  huff_packer #(.WORD_W(DATA_W)) u_pack (
    .clk_i, .rst_ni, .clr_i(start_ok), .mode8_i(mode8_q),
    .sym_valid_i(sym_fire), .sym_i(rd_data_i[7:0]),
    .take_i(wr_fire), .word_rdy_o(word_rdy), .word_o(word_v)
  );

  always_comb begin
    rd_req_o  = 1'b0;
    rd_word_o = 1'b0;
    rd_addr_o = '0;
    unique case (state_q)
      ST_HDR:  begin rd_req_o = 1'b1; rd_word_o = 1'b1; rd_addr_o = src_q;    end
      ST_TSZ:  begin rd_req_o = 1'b1; rd_addr_o = hdr_next;                   end
      ST_ROOT: begin rd_req_o = 1'b1; rd_addr_o = base_q;                     end
      ST_BITS: begin rd_req_o = 1'b1; rd_word_o = 1'b1; rd_addr_o = bits_q;   end
      ST_NODE: begin rd_req_o = 1'b1; rd_addr_o = child_addr;                 end
      default: ;
    endcase
  end

  assign wr_req_o  = (state_q == ST_WRITE);
  assign wr_addr_o = dst_q;
  assign wr_data_o = word_v;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      src_q        <= '0;
      base_q       <= '0;
      bits_q       <= '0;
      dst_q        <= '0;
      rem_q        <= '0;
      pos_q        <= '0;
      cur_q        <= '0;
      root_q       <= '0;
      mode8_q      <= 1'b0;
      need_fetch_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          src_q   <= src_addr_i;
          base_q  <= src_addr_i + ADDR_W'(5);
          dst_q   <= dst_addr_i;
          pos_q   <= '0;
          need_fetch_q <= 1'b0;
          state_q <= ST_HDR;
        end
        ST_HDR: if (rd_fire) begin
          mode8_q <= (rd_data_i[3:0] == MODE8_CODE);
          rem_q   <= $signed({1'b0, hdr_len});
          state_q <= abort_v ? ST_DONE : ST_TSZ;
        end
        ST_TSZ: if (rd_fire) begin
          bits_q  <= base_q + ADDR_W'({rd_data_i[7:0], 1'b0}) + ADDR_W'(1);
          state_q <= ST_ROOT;
        end
        ST_ROOT: if (rd_fire) begin
          root_q  <= rd_data_i[7:0];
          cur_q   <= rd_data_i[7:0];
          state_q <= ST_BITS;
        end
        ST_BITS: if (rd_fire) begin
          bits_q       <= bits_q + ADDR_W'(4);
          need_fetch_q <= 1'b0;
          state_q      <= (rem_q <= 0) ? ST_DONE : ST_NODE;
        end
        ST_NODE: if (rd_fire) begin
          need_fetch_q <= last_v;
          if (leaf_v) begin
            pos_q <= '0;
            cur_q <= root_q;
          end else begin
            pos_q <= pos_nxt;
            cur_q <= rd_data_i[7:0];
          end
          state_q <= ST_ADV;
        end
        ST_ADV: state_q <= word_rdy ? ST_WRITE : (need_fetch_q ? ST_BITS : ST_NODE);
        ST_WRITE: if (wr_fire) begin
          dst_q   <= dst_q + ADDR_W'(WBYTES);
          rem_q   <= rem_after;
          state_q <= (rem_after <= 0) ? ST_DONE : (need_fetch_q ? ST_BITS : ST_NODE);
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_one_port_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
  assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_word_o));
  assert_wr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));
  assert_done_in_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  assert_done_ends_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_busy_falls_after_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
  assert_leaf_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_fire |=> (cur_q == root_q));
endmodule

// File: tb/sim_huff_decoder.sv
`timescale 1ns/1ps
module sim_huff_decoder;
  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [31:0] src_addr_i = '0, dst_addr_i = '0;
  logic busy_o, done_o, rd_req_o, rd_word_o, wr_req_o;
  logic [31:0] rd_addr_o, wr_addr_o, wr_data_o;
  logic rd_valid_i = 1'b0, wr_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;

  always #2.5 clk_i = ~clk_i;

  huff_decoder u0 (.*);

  int errors = 0, checks = 0;
  logic [7:0]  mem [0:4095];
  logic [31:0] exp_words [0:63];
  int n_exp;
  logic stream [0:2047];
  int sel_arr [0:511];
  logic [7:0] leafv [0:2];
  logic [31:0] rd_log_addr [0:511];
  logic rd_log_word [0:511];
  logic [31:0] wr_log_addr [0:63], wr_log_data [0:63];
  int n_rd, n_wr, n_txn;
  logic [31:0] pend_addr;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) mem[(a + i) & 4095] = w[8*i +: 8];
  endtask

  // memory responder
  initial begin
    n_txn = 0;
    forever begin
      @(negedge clk_i);
      rd_valid_i = 1'b0;
      wr_ack_i   = 1'b0;
      if (rd_req_o && wr_req_o) chk(1'b0, "R10 both requests", 32'd1, 32'd0);
      if (rd_req_o) begin
        pend_addr = rd_addr_o;
        for (int k = 0; k < n_txn % 3; k++) begin
          @(negedge clk_i);
          if (rd_addr_o !== pend_addr || !rd_req_o) chk(1'b0, "R10 read held", rd_addr_o, pend_addr);
        end
        if (rd_word_o)
          rd_data_i = {mem[(pend_addr+3) & 4095], mem[(pend_addr+2) & 4095],
                       mem[(pend_addr+1) & 4095], mem[pend_addr & 4095]};
        else
          rd_data_i = {24'h0, mem[pend_addr & 4095]};
        if (n_rd < 512) begin
          rd_log_addr[n_rd] = pend_addr;
          rd_log_word[n_rd] = rd_word_o;
        end
        n_rd++;
        n_txn++;
        rd_valid_i = 1'b1;
      end else if (wr_req_o) begin
        pend_addr = wr_addr_o;
        for (int k = 0; k < n_txn % 3; k++) begin
          @(negedge clk_i);
          if (wr_addr_o !== pend_addr || !wr_req_o) chk(1'b0, "R10 write held", wr_addr_o, pend_addr);
        end
        if (n_wr < 64) begin
          wr_log_addr[n_wr] = wr_addr_o;
          wr_log_data[n_wr] = wr_data_o;
        end
        n_wr++;
        n_txn++;
        wr_ack_i = 1'b1;
      end
    end
  end

  // tree: root 0x80, [1]=A, [2]=0xC1, [3..4]=filler, [5]=B, [6]=C; codes A=0, B=10, C=11
  task automatic setup_job(input logic [31:0] src, input logic [3:0] mode_nib, input int len,
                           input int seed, input logic [7:0] la, input logic [7:0] lb, input logic [7:0] lc);
    int b, nw, nsym, nbits;
    logic [7:0] byt;
    logic [31:0] w;
    b = int'(src[11:0]);
    put_word(b, {len[23:0], 4'h0, mode_nib});
    mem[(b+4) & 4095] = 8'd3;
    mem[(b+5) & 4095] = 8'h80;  mem[(b+6) & 4095] = la;
    mem[(b+7) & 4095] = 8'hC1;  mem[(b+8) & 4095] = 8'hEE;
    mem[(b+9) & 4095] = 8'hEE;  mem[(b+10) & 4095] = lb;
    mem[(b+11) & 4095] = lc;
    leafv[0] = la; leafv[1] = lb; leafv[2] = lc;
    nw = (len + 3) / 4;
    nsym = (mode_nib == 4'h8) ? nw * 4 : nw * 8;
    nbits = 0;
    for (int i = 0; i < nsym; i++) begin
      sel_arr[i] = (i + i / 3 + seed) % 3;
      if (sel_arr[i] == 0) begin stream[nbits] = 1'b0; nbits++; end
      else begin
        stream[nbits] = 1'b1; stream[nbits+1] = (sel_arr[i] == 2); nbits += 2;
      end
    end
    for (int wi = 0; wi < (nbits + 31) / 32 + 1; wi++) begin
      w = '0;
      for (int k = 0; k < 32; k++)
        if (wi*32 + k < nbits) w[31-k] = stream[wi*32 + k];
      put_word(b + 12 + 4*wi, w);
    end
    for (int j = 0; j < nw * 4; j++) begin
      if (mode_nib == 4'h8) byt = leafv[sel_arr[j]];
      else byt = {leafv[sel_arr[2*j+1]][3:0], leafv[sel_arr[2*j]][3:0]};
      exp_words[j/4][8*(j%4) +: 8] = byt;
    end
    n_exp = nw;
  endtask

  task automatic run_job(input logic [31:0] src, input logic [31:0] dst, input bit poke, output bit seen);
    n_rd = 0; n_wr = 0; seen = 1'b0;
    @(negedge clk_i);
    start_i = 1'b1; src_addr_i = src; dst_addr_i = dst;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R11 busy after start", {31'd0, busy_o}, 32'd1);
    for (int c = 0; c < 20000; c++) begin
      if (poke && c == 30) begin start_i = 1'b1; src_addr_i = 32'h0200_0800; dst_addr_i = 32'h0; end
      else start_i = 1'b0;
      @(negedge clk_i);
      if (done_o) begin seen = 1'b1; break; end
    end
    start_i = 1'b0;
    chk(seen, "R11 done seen", {31'd0, seen}, 32'd1);
    @(negedge clk_i);
    chk(busy_o === 1'b0, "R11 busy low after done", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic check_output(input logic [31:0] src, input logic [31:0] dst, input string tag);
    logic [31:0] last_bits;
    chk(n_wr == n_exp, {"R8 write count ", tag}, n_wr, n_exp);
    for (int i = 0; i < n_exp && i < n_wr; i++) begin
      chk(wr_log_data[i] === exp_words[i], tag, wr_log_data[i], exp_words[i]);
      chk(wr_log_addr[i] === dst + 4*i, "R8 write address", wr_log_addr[i], dst + 4*i);
    end
    chk(rd_log_addr[0] === src && rd_log_word[0], "R2 header read", rd_log_addr[0], src);
    chk(rd_log_addr[1] === src + 4 && !rd_log_word[1], "R2 tree size read", rd_log_addr[1], src + 4);
    chk(rd_log_addr[2] === src + 5 && !rd_log_word[2], "R2 root read", rd_log_addr[2], src + 5);
    chk(rd_log_addr[3] === src + 12 && rd_log_word[3], "R2 first bitstream read", rd_log_addr[3], src + 12);
    last_bits = src + 12;
    for (int i = 4; i < n_rd && i < 512; i++)
      if (rd_log_word[i]) begin
        chk(rd_log_addr[i] === last_bits + 4, "R3 next bitstream word", rd_log_addr[i], last_bits + 4);
        last_bits = rd_log_addr[i];
      end
  endtask

  task automatic t_reset();
    chk(busy_o === 1'b0, "R11 reset busy", {31'd0, busy_o}, 32'd0);
    chk(done_o === 1'b0, "R11 reset done", {31'd0, done_o}, 32'd0);
    chk(rd_req_o === 1'b0, "R10 reset rd_req", {31'd0, rd_req_o}, 32'd0);
    chk(wr_req_o === 1'b0, "R10 reset wr_req", {31'd0, wr_req_o}, 32'd0);
  endtask

  task automatic t_mode8_long();  // also start while busy
    bit seen;
    int wr_before;
    setup_job(32'h0200_0000, 4'h8, 32, 0, 8'h5C, 8'hA3, 8'h07);
    run_job(32'h0200_0000, 32'h0300_0040, 1'b1, seen);
    check_output(32'h0200_0000, 32'h0300_0040, "R1 R4 R5 R6 R8 mode8 data");
    wr_before = n_wr;
    repeat (50) @(negedge clk_i);
    chk(n_wr == wr_before && !busy_o, "R11 start while busy ignored", n_wr, wr_before);
  endtask

  task automatic t_mode4();
    bit seen;
    setup_job(32'h0200_0400, 4'h3, 12, 1, 8'h01, 8'h0A, 8'h05);
    run_job(32'h0200_0400, 32'h0300_0100, 1'b0, seen);
    check_output(32'h0200_0400, 32'h0300_0100, "R1 R7 mode4 data");
  endtask

  task automatic t_odd_len();
    bit seen;
    setup_job(32'h0200_0600, 4'h8, 6, 2, 8'h3C, 8'hF0, 8'h99);
    run_job(32'h0200_0600, 32'h0300_0200, 1'b0, seen);
    check_output(32'h0200_0600, 32'h0300_0200, "R8 short length data");
  endtask

  task automatic t_abort(input logic [31:0] src, input int len, input string tag);
    bit seen;
    put_word(int'(src[11:0]), {len[23:0], 8'h08});
    run_job(src, 32'h0300_0300, 1'b0, seen);
    chk(n_wr == 0, tag, n_wr, 0);
    chk(seen, "R9 abort done", {31'd0, seen}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_mode8_long();
    t_mode4();
    t_odd_len();
    t_abort(32'h0000_0100, 16, "R9 low region no writes");
    t_abort(32'h0FFF_FF00, 32'h200, "R9 end wraps out of region");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule